// File: doc/BRIEF.md
# Accelerometer Bring-up and Readout Sequencer

This block is the control sequencer for a three-axis accelerometer on an I2C bus. After reset it reads two identity registers. If both hold their expected values, it runs a fixed five-step configuration that ends with the sensor in active mode. If either value is wrong, it stops in an identity-failure state and configures nothing.

Once the sensor is active, each sample request causes one 8-byte burst read of the status block. The block splits that burst into three sign-extended axis values and flags them with a single-cycle strobe. A shutdown request puts the sensor into standby and then off. A start request reruns the configuration from its first step. It also serves as the way out of a transfer fault.

The sequencer does not drive the bus wires. It talks to a byte-level I2C master through three streams:

- **Command stream.** Holds `cmd_valid` with the device address, register pointer, write length and read length stable until `cmd_ready` is high.
- **Write-byte stream.** Holds `wr_valid` with `wr_data` stable until `wr_ready` is high.
- **Read-byte stream.** Has no back-pressure: every `rd_valid` byte is taken on that cycle.

The master reports the end of each transaction on `xfer_done`, with `xfer_nack` qualifying it. It must deliver all read bytes before the cycle that carries `xfer_done`. The axis strobe has no ready and must be taken when it is high.

Top module: `accel_seq`

## Requirements
- R1: After reset, the first two commands are single-byte reads (write length 0, read length 1): first from register 0x12, then from register 0x1C. Configuration starts only if they return 0x55 and 0xAA.
- R2: If either identity byte differs, `id_fail` goes high and stays high until reset. No further command is issued and `start_req` has no effect.
- R3: Configuration is five writes, in this order:
  - register 0x21 with {0x52};
  - register 0x00 with {0x02, 0x12, 0x02, 0x82, 0x02};
  - register 0x1F with {0x08};
  - register 0x0C with {0x8F, 0x74, 0x00, 0x11, 0x00, 0x07};
  - register 0x00 with {0x06}.
  After the last one completes, `active` goes high.
- R4: `cmd_valid` and its fields hold until `cmd_ready`, and `wr_valid`/`wr_data` hold until `wr_ready`. `busy` is high while any command is outstanding, and it is low in reset.
- R5: A sample is exactly one command: a read of 8 bytes from register 0x12 with write length 0. No per-axis register is ever read.
- R6: The burst bytes form four little-endian 16-bit words (byte 2k is the low byte of word k). X, Y and Z are words 1, 2 and 3. Each result is the word's bits 12:0 read as a 13-bit signed value. `axis_valid` is high for one cycle, the cycle after the `xfer_done` of that read.
- R7: `sample_req` is ignored unless the block is active with no sample already running.
- R8: `shutdown_req` while active issues one write to register 0x00 with {0x02, 0x00}. `active` drops, and the block waits in the off state.
- R9: If `sample_req` and `shutdown_req` arrive in the same cycle, the shutdown is served and the sample is dropped.
- R10: A NACK on any transaction aborts the sequence. `fault` then goes high and stays high, `active` is low, and no further command is issued.
- R11: `start_req` in the off or fault state clears `fault` and reruns configuration from the 0x21 write, without rechecking identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Rerun configuration (resume, fault recovery) |
| shutdown_req | input | 1 | Put sensor in standby then off |
| sample_req | input | 1 | Request one axis sample |
| cmd_valid | output | 1 | Command offered to the I2C master |
| cmd_ready | input | 1 | Master accepts the command |
| cmd_dev | output | 7 | 7-bit device address |
| cmd_reg | output | 8 | Register pointer |
| cmd_wlen | output | 4 | Write bytes that follow the pointer |
| cmd_rlen | output | 4 | Bytes to read after the pointer |
| wr_valid | output | 1 | Write byte available |
| wr_ready | input | 1 | Master takes the write byte |
| wr_data | output | 8 | Write byte |
| rd_valid | input | 1 | Read byte strobe |
| rd_data | input | 8 | Read byte |
| xfer_done | input | 1 | Transaction finished |
| xfer_nack | input | 1 | Finished transaction was not acknowledged |
| busy | output | 1 | A command is outstanding |
| active | output | 1 | Sensor configured and sampling allowed |
| id_fail | output | 1 | Identity check failed |
| fault | output | 1 | Sticky NACK fault |
| axis_valid | output | 1 | One-cycle strobe for new axis values |
| axis_x | output | 13 | Signed X count (128 = 1 g) |
| axis_y | output | 13 | Signed Y count |
| axis_z | output | 13 | Signed Z count |

## Verification
Two requests can land on the same edge:
- A sample request and a shutdown request arriving together in the active state. The bench raises both on one cycle. It then judges by the command log: exactly one write to register 0x00 carrying {0x02, 0x00}, no 8-byte read, no axis strobe, and `active` low.
- A repeated sample request during a running burst. The bench holds `sample_req` across the read and expects only one command.

// File: rtl/accel_seq_pkg.sv
package accel_seq_pkg;

  localparam int LEN_W = 4;
  localparam logic [7:0] ID_A_VAL = 8'h55;
  localparam logic [7:0] ID_B_VAL = 8'hAA;

  typedef enum logic [3:0] {
    STP_ID_A, STP_ID_B, STP_PWR, STP_MODES, STP_OSC,
    STP_AFE, STP_GO, STP_READ, STP_STOP
  } step_t;

  function automatic logic [7:0] step_reg(step_t s);
    case (s)
      STP_ID_A, STP_READ: return 8'h12;
      STP_ID_B:           return 8'h1C;
      STP_PWR:            return 8'h21;
      STP_OSC:            return 8'h1F;
      STP_AFE:            return 8'h0C;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] step_wlen(step_t s);
    case (s)
      STP_PWR, STP_OSC, STP_GO: return 4'd1;
      STP_MODES:                return 4'd5;
      STP_AFE:                  return 4'd6;
      STP_STOP:                 return 4'd2;
      default:                  return 4'd0;
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] step_rlen(step_t s);
    case (s)
      STP_ID_A, STP_ID_B: return 4'd1;
      STP_READ:           return 4'd8;
      default:            return 4'd0;
    endcase
  endfunction

  function automatic logic [7:0] step_byte(step_t s, logic [LEN_W-1:0] i);
    case (s)
      STP_PWR: return 8'h52;
      STP_OSC: return 8'h08;
      STP_GO:  return 8'h06;
      STP_MODES:
        case (i)
          4'd1:    return 8'h12;
          4'd3:    return 8'h82;
          default: return 8'h02;
        endcase
      STP_AFE:
        case (i)
          4'd0:    return 8'h8F;
          4'd1:    return 8'h74;
          4'd3:    return 8'h11;
          4'd5:    return 8'h07;
          default: return 8'h00;
        endcase
      STP_STOP: return (i == 4'd0) ? 8'h02 : 8'h00;
      default:  return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/accel_xfer.sv
module accel_xfer
  import accel_seq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  step_t            step,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [6:0]       cmd_dev,
  output logic [7:0]       cmd_reg,
  output logic [LEN_W-1:0] cmd_wlen,
  output logic [LEN_W-1:0] cmd_rlen,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [7:0]       wr_data,
  input  logic             xfer_done,
  input  logic             xfer_nack,
  output logic             busy,
  output logic             fin,
  output logic             fin_nack
);

  typedef enum logic [1:0] {X_IDLE, X_CMD, X_WAIT} xst_t;

  xst_t             st;
  step_t            step_q;
  logic [LEN_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= X_IDLE;
      step_q <= STP_ID_A;
      idx    <= '0;
    end else begin
      case (st)
        X_IDLE: if (go) begin
          step_q <= step;
          idx    <= '0;
          st     <= X_CMD;
        end
        X_CMD: if (cmd_ready) st <= X_WAIT;
        X_WAIT: begin
          if (wr_valid && wr_ready) idx <= idx + 1'b1;
          if (xfer_done) st <= X_IDLE;
        end
        default: st <= X_IDLE;
      endcase
    end
  end

  assign cmd_valid = (st == X_CMD);
  assign cmd_dev   = DEV_ADDR;
  assign cmd_reg   = step_reg(step_q);
  assign cmd_wlen  = step_wlen(step_q);
  assign cmd_rlen  = step_rlen(step_q);
  assign wr_valid  = (st == X_WAIT) && (idx < step_wlen(step_q));
  assign wr_data   = step_byte(step_q, idx);
  assign busy      = (st != X_IDLE);
  assign fin       = (st == X_WAIT) && xfer_done;
  assign fin_nack  = xfer_nack;

endmodule

// File: rtl/accel_unpack.sv
module accel_unpack #(
  parameter int BLOCK_BYTES = 8,
  parameter int SIGN_BIT    = 12,
  parameter int N_AXES      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         rd_valid,
  input  logic [7:0]                   rd_data,
  input  logic                         latch,
  output logic [7:0]                   first_byte,
  output logic                         axis_valid,
  output logic [N_AXES*(SIGN_BIT+1)-1:0] axes
);

  localparam int AXIS_W = SIGN_BIT + 1;
  localparam int CNT_W  = $clog2(BLOCK_BYTES);

  logic [7:0]   buf_q [BLOCK_BYTES];
  logic [CNT_W:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < BLOCK_BYTES; i++) buf_q[i] <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (rd_valid && (cnt < (CNT_W+1)'(BLOCK_BYTES))) begin
      buf_q[cnt[CNT_W-1:0]] <= rd_data;
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) axis_valid <= 1'b0;
    else        axis_valid <= latch;
  end

  assign first_byte = buf_q[0];

  for (genvar a = 0; a < N_AXES; a++) begin : g_axis
    logic [15:0]       word;
    logic [AXIS_W-1:0] val_q;
    assign word = {buf_q[2*a+3], buf_q[2*a+2]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     val_q <= '0;
      else if (latch) val_q <= word[AXIS_W-1:0];
    end
    assign axes[a*AXIS_W +: AXIS_W] = val_q;
  end

endmodule

// File: rtl/accel_seq.sv
module accel_seq
  import accel_seq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h18,
  parameter int         SIGN_BIT = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic                shutdown_req,
  input  logic                sample_req,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [6:0]          cmd_dev,
  output logic [7:0]          cmd_reg,
  output logic [3:0]          cmd_wlen,
  output logic [3:0]          cmd_rlen,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [7:0]          wr_data,
  input  logic                rd_valid,
  input  logic [7:0]          rd_data,
  input  logic                xfer_done,
  input  logic                xfer_nack,
  output logic                busy,
  output logic                active,
  output logic                id_fail,
  output logic                fault,
  output logic                axis_valid,
  output logic [SIGN_BIT:0]   axis_x,
  output logic [SIGN_BIT:0]   axis_y,
  output logic [SIGN_BIT:0]   axis_z
);

  localparam int AXIS_W = SIGN_BIT + 1;

  typedef enum logic [2:0] {
    ST_RUN, ST_ACTIVE, ST_SAMPLE, ST_SHUT, ST_OFF, ST_FAULT, ST_IDFAIL
  } st_t;

  st_t     state;
  step_t   step_q;
  logic    issue_q;
  logic    fault_q;
  logic    fin, fin_nack;
  logic    latch;
  logic [7:0] first_byte;
  logic [3*AXIS_W-1:0] axes;

  accel_xfer #(.DEV_ADDR(DEV_ADDR)) u_xfer (
    .clk, .rst_n,
    .go(issue_q), .step(step_q),
    .cmd_valid, .cmd_ready, .cmd_dev, .cmd_reg, .cmd_wlen, .cmd_rlen,
    .wr_valid, .wr_ready, .wr_data,
    .xfer_done, .xfer_nack,
    .busy, .fin, .fin_nack
  );

  assign latch = fin && !fin_nack && (state == ST_SAMPLE);

  accel_unpack #(.BLOCK_BYTES(8), .SIGN_BIT(SIGN_BIT), .N_AXES(3)) u_unpack (
    .clk, .rst_n,
    .clr(issue_q), .rd_valid, .rd_data, .latch,
    .first_byte, .axis_valid, .axes
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RUN;
      step_q  <= STP_ID_A;
      issue_q <= 1'b1;
      fault_q <= 1'b0;
    end else begin
      issue_q <= 1'b0;
      case (state)
        ST_RUN: if (fin) begin
          if (fin_nack) begin
            fault_q <= 1'b1;
            state   <= ST_FAULT;
          end else begin
            case (step_q)
              STP_ID_A:
                if (first_byte == ID_A_VAL) begin step_q <= STP_ID_B; issue_q <= 1'b1; end
                else state <= ST_IDFAIL;
              STP_ID_B:
                if (first_byte == ID_B_VAL) begin step_q <= STP_PWR; issue_q <= 1'b1; end
                else state <= ST_IDFAIL;
              STP_PWR:   begin step_q <= STP_MODES; issue_q <= 1'b1; end
              STP_MODES: begin step_q <= STP_OSC;   issue_q <= 1'b1; end
              STP_OSC:   begin step_q <= STP_AFE;   issue_q <= 1'b1; end
              STP_AFE:   begin step_q <= STP_GO;    issue_q <= 1'b1; end
              default:   state <= ST_ACTIVE;
            endcase
          end
        end
        ST_ACTIVE:
          if (shutdown_req) begin
            step_q <= STP_STOP; issue_q <= 1'b1; state <= ST_SHUT;
          end else if (sample_req) begin
            step_q <= STP_READ; issue_q <= 1'b1; state <= ST_SAMPLE;
          end
        ST_SAMPLE, ST_SHUT: if (fin) begin
          if (fin_nack) begin
            fault_q <= 1'b1;
            state   <= ST_FAULT;
          end else begin
            state <= (state == ST_SAMPLE) ? ST_ACTIVE : ST_OFF;
          end
        end
        ST_OFF, ST_FAULT: if (start_req) begin
          fault_q <= 1'b0;
          step_q  <= STP_PWR;
          issue_q <= 1'b1;
          state   <= ST_RUN;
        end
        default: state <= ST_IDFAIL;
      endcase
    end
  end

  assign active  = (state == ST_ACTIVE) || (state == ST_SAMPLE);
  assign id_fail = (state == ST_IDFAIL);
  assign fault   = fault_q;
  assign axis_x  = axes[0*AXIS_W +: AXIS_W];
  assign axis_y  = axes[1*AXIS_W +: AXIS_W];
  assign axis_z  = axes[2*AXIS_W +: AXIS_W];

endmodule

// File: rtl/accel_seq_checker.sv
module accel_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_reg,
  input logic [3:0] cmd_wlen,
  input logic [3:0] cmd_rlen,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_data,
  input logic       xfer_done,
  input logic       xfer_nack,
  input logic       busy,
  input logic       active,
  input logic       id_fail,
  input logic       fault,
  input logic       axis_valid
);

  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_reg) && $stable(cmd_wlen) && $stable(cmd_rlen));

  assert_cmd_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));

  assert_burst_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_rlen > 4'd1 |-> cmd_reg == 8'h12 && cmd_rlen == 4'd8 && cmd_wlen == 4'd0);

  assert_strobe_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    axis_valid |=> !axis_valid);

  assert_idfail_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    id_fail |-> !cmd_valid && !active);

  assert_idfail_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    id_fail |=> id_fail);

  assert_nack_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && xfer_done && xfer_nack |=> fault);

  assert_fault_inactive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !active && !cmd_valid);

endmodule

bind accel_seq accel_seq_checker u_chk (.*);

// File: tb/accel_seq_test.sv
`timescale 1ns/1ps
module accel_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 0, shutdown_req = 0, sample_req = 0;
  logic cmd_valid, cmd_ready = 0;
  logic [6:0] cmd_dev;
  logic [7:0] cmd_reg;
  logic [3:0] cmd_wlen, cmd_rlen;
  logic wr_valid, wr_ready = 0;
  logic [7:0] wr_data;
  logic rd_valid = 0;
  logic [7:0] rd_data = 0;
  logic xfer_done = 0, xfer_nack = 0;
  logic busy, active, id_fail, fault, axis_valid;
  logic [12:0] axis_x, axis_y, axis_z;

  always #2.5 clk = ~clk;

  accel_seq uut (.*);

  int total = 0, bad = 0;
  int n_cmd = 0, nack_at = -1, wr_miss = 0;
  logic [7:0] id_a_resp = 8'h55, id_b_resp = 8'hAA;
  logic [7:0] smp [8];
  int log_reg [64], log_wl [64], log_rl [64];
  logic [7:0] log_b [64][8];
  int strobes = 0;

  // I2C master model
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid) begin
        int c, wl, rl;
        c = n_cmd; n_cmd++;
        wl = cmd_wlen; rl = cmd_rlen;
        if (c < 64) begin log_reg[c] = cmd_reg; log_wl[c] = wl; log_rl[c] = rl; end
        cmd_ready = 1; @(negedge clk); cmd_ready = 0;
        wr_ready = 1;
        for (int i = 0; i < wl; i++) begin
          if (!wr_valid) wr_miss++;
          if (c < 64 && i < 8) log_b[c][i] = wr_data;
          @(negedge clk);
        end
        wr_ready = 0;
        for (int i = 0; i < rl; i++) begin
          rd_valid = 1;
          if (rl == 8) rd_data = smp[i];
          else rd_data = (cmd_reg == 8'h12) ? id_a_resp : id_b_resp;
          @(negedge clk);
        end
        rd_valid = 0;
        xfer_done = 1; xfer_nack = (c == nack_at);
        @(negedge clk);
        xfer_done = 0; xfer_nack = 0;
      end
    end
  end

  always @(posedge clk) if (axis_valid) strobes++;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_active(int lim);
    for (int i = 0; i < lim && !active; i++) @(negedge clk);
  endtask

  task automatic pulse_sample();
    @(negedge clk); sample_req = 1; @(negedge clk); sample_req = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_req = 1; @(negedge clk); start_req = 0;
  endtask

  function automatic int exp_reg(int s);
    case (s) 0: return 'h21; 1: return 'h00; 2: return 'h1F; 3: return 'h0C; default: return 'h00; endcase
  endfunction
  function automatic int exp_wl(int s);
    case (s) 1: return 5; 3: return 6; default: return 1; endcase
  endfunction
  function automatic int exp_byte(int s, int i);
    case (s)
      0: return 'h52;
      1: case (i) 1: return 'h12; 3: return 'h82; default: return 'h02; endcase
      2: return 'h08;
      3: case (i) 0: return 'h8F; 1: return 'h74; 3: return 'h11; 5: return 'h07; default: return 0; endcase
      default: return 'h06;
    endcase
  endfunction

  // R3 / R11: five config writes starting at log index base
  task automatic check_config(int base, string req);
    for (int s = 0; s < 5; s++) begin
      chk(req, $sformatf("cfg%0d reg", s), log_reg[base+s], exp_reg(s));
      chk(req, $sformatf("cfg%0d wlen", s), log_wl[base+s], exp_wl(s));
      chk(req, $sformatf("cfg%0d rlen", s), log_rl[base+s], 0);
      for (int i = 0; i < exp_wl(s); i++)
        chk(req, $sformatf("cfg%0d byte%0d", s, i), log_b[base+s][i], exp_byte(s, i));
    end
  endtask

  task automatic do_reset(logic [7:0] ida, logic [7:0] idb);
    rst_n = 0; nack_at = -1; id_a_resp = ida; id_b_resp = idb;
    cycles(3);
    n_cmd = 0;
    chk("R4", "reset busy", busy, 0);
    chk("R4", "reset cmd_valid", cmd_valid, 0);
    chk("R4", "reset active", active, 0);
    chk("R6", "reset axis_valid", axis_valid, 0);
    rst_n = 1;
  endtask

  task automatic t_bringup();
    do_reset(8'h55, 8'hAA);
    wait_active(400);
    chk("R3", "active after config", active, 1);
    chk("R1", "command count", n_cmd, 7);
    chk("R1", "id A reg", log_reg[0], 'h12);
    chk("R1", "id A rlen", log_rl[0], 1);
    chk("R1", "id A wlen", log_wl[0], 0);
    chk("R1", "id B reg", log_reg[1], 'h1C);
    chk("R1", "id B rlen", log_rl[1], 1);
    check_config(2, "R3");
    chk("R4", "write byte offered when taken", wr_miss, 0);
    chk("R10", "no fault", fault, 0);
  endtask

  task automatic t_sample(logic [15:0] wx, logic [15:0] wy, logic [15:0] wz,
                          int ex, int ey, int ez);
    int v, s0;
    smp[0] = 8'hA5; smp[1] = 8'h5A;
    smp[2] = wx[7:0]; smp[3] = wx[15:8];
    smp[4] = wy[7:0]; smp[5] = wy[15:8];
    smp[6] = wz[7:0]; smp[7] = wz[15:8];
    n_cmd = 0; s0 = strobes;
    pulse_sample();
    for (int i = 0; i < 60 && strobes == s0; i++) @(negedge clk);
    chk("R6", "strobe count", strobes - s0, 1);
    @(negedge clk);
    chk("R6", "strobe single cycle", axis_valid, 0);
    chk("R5", "sample cmds", n_cmd, 1);
    chk("R5", "sample reg", log_reg[0], 'h12);
    chk("R5", "sample rlen", log_rl[0], 8);
    chk("R5", "sample wlen", log_wl[0], 0);
    v = $signed(axis_x); chk("R6", "axis x", v, ex);
    v = $signed(axis_y); chk("R6", "axis y", v, ey);
    v = $signed(axis_z); chk("R6", "axis z", v, ez);
  endtask

  task automatic t_sample_busy();
    int s0;
    n_cmd = 0; s0 = strobes;
    @(negedge clk); sample_req = 1; cycles(4); sample_req = 0;
    cycles(40);
    chk("R7", "one read while held", n_cmd, 1);
    chk("R7", "one strobe while held", strobes - s0, 1);
  endtask

  task automatic t_collide();
    int s0;
    n_cmd = 0; s0 = strobes;
    @(negedge clk); sample_req = 1; shutdown_req = 1;
    @(negedge clk); sample_req = 0; shutdown_req = 0;
    cycles(30);
    chk("R9", "cmds on collision", n_cmd, 1);
    chk("R9", "no strobe on collision", strobes - s0, 0);
    chk("R8", "shutdown reg", log_reg[0], 'h00);
    chk("R8", "shutdown wlen", log_wl[0], 2);
    chk("R8", "shutdown byte0", log_b[0][0], 'h02);
    chk("R8", "shutdown byte1", log_b[0][1], 'h00);
    chk("R8", "inactive after shutdown", active, 0);
    n_cmd = 0;
    pulse_sample(); cycles(20);
    chk("R7", "sample while off", n_cmd, 0);
  endtask

  task automatic t_resume();
    n_cmd = 0;
    pulse_start();
    wait_active(400);
    chk("R11", "active after resume", active, 1);
    chk("R11", "resume cmd count", n_cmd, 5);
    check_config(0, "R11");
  endtask

  task automatic t_nack();
    int s0;
    n_cmd = 0; nack_at = 0; s0 = strobes;
    pulse_sample(); cycles(40);
    nack_at = -1;
    chk("R10", "fault set", fault, 1);
    chk("R10", "inactive on fault", active, 0);
    chk("R10", "no strobe on nack", strobes - s0, 0);
    n_cmd = 0;
    pulse_sample(); cycles(20);
    chk("R10", "no command in fault", n_cmd, 0);
    chk("R10", "fault sticky", fault, 1);
    pulse_start();
    chk("R11", "fault cleared", fault, 0);
    wait_active(400);
    chk("R11", "active after recovery", active, 1);
    chk("R11", "recovery first reg", log_reg[0], 'h21);
  endtask

  task automatic t_idfail(logic [7:0] ida, logic [7:0] idb, int ncmd);
    do_reset(ida, idb);
    cycles(60);
    chk("R2", "id_fail", id_fail, 1);
    chk("R2", "cmds before stop", n_cmd, ncmd);
    chk("R2", "inactive", active, 0);
    pulse_start(); cycles(30);
    chk("R2", "start ignored", n_cmd, ncmd);
    chk("R2", "id_fail held", id_fail, 1);
  endtask

  initial begin
    t_bringup();
    t_sample(16'h0080, 16'h1F80, 16'hE005, 128, -128, 5);
    t_sample(16'h1000, 16'h0FFF, 16'hFFFF, -4096, 4095, -1);
    t_sample_busy();
    t_collide();
    t_resume();
    t_sample(16'h0000, 16'h0001, 16'h1FFF, 0, 1, -1);
    t_nack();
    t_idfail(8'h55, 8'hAB, 2);
    t_idfail(8'h54, 8'hAA, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #750000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule